// File: doc/BRIEF.md
# Call-Sequence Interrupt Controller Responder

This block collects up to eight interrupt requests and picks one of them by fixed priority. It signals the processor on a single request line. It then answers the processor's acknowledge pulses with a complete three-byte subroutine call. The first pulse returns the call opcode. The second returns the high byte of the service routine address. The third returns the low byte. Because the routine address comes from programmable setup words and not from a hard-wired restart code, each handler can sit anywhere in a 16-bit address space.

Software configures the block once with two setup words through a small write port. The first word gives the low-byte base bits and the spacing between vectors. The second word gives the high address byte. The controller keeps the request line low until both words have been written. Each request input is edge-captured into a pending bit. The pending bit stays set until that level's call sequence finishes.

Top module: `callseq_irq_ctrl`

## Requirements
- R1: The request output stays low until setup word one (cfg_sel=0) and setup word two (cfg_sel=1) have both been written since reset. A request captured before that point is kept, and it raises the request output once setup is complete.
- R2: A low-to-high transition on any request input sets that level's pending bit on the next rising clock edge. While the block is set up and idle, any pending bit drives the request output high.
- R3: Priority is fixed. Input 0 is the highest and input 7 the lowest, so the serviced level is the lowest-numbered pending input.
- R4: While the acknowledge input is low on the first pulse of a sequence, the data bus carries 0xCD with the drive enable high. The drive enable is never high while the acknowledge input is high.
- R5: During the second acknowledge pulse, the data bus carries setup word two, which is the high address byte.
- R6: During the third acknowledge pulse, the data bus carries the low byte, computed modulo 256 as {word1[7:5],5'b00000} + level × spacing. Word1 bit 2 set selects a spacing of 4 bytes, and bit 2 clear selects a spacing of 8 bytes.
- R7: The serviced level is frozen at the falling edge of the first acknowledge. A higher-priority request that arrives later in the sequence does not change the low byte.
- R8: The request output is low from the start of the first acknowledge pulse until the third pulse ends.
- R9: When the third acknowledge pulse ends, the sequence returns to idle and only the serviced level's pending bit is cleared. Any other pending level raises the request output again.
- R10: Reset clears all pending bits and both setup flags, and returns the sequence to idle. The request output and the drive enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request inputs, edge captured |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_sel | input | 1 | 0 selects setup word one, 1 selects setup word two |
| cfg_wdata | input | 8 | Setup word data |
| inta_n | input | 1 | Acknowledge from processor, active low, one pulse per byte |
| intr_o | output | 1 | Request to processor |
| dbus_o | output | 8 | Byte driven during acknowledge |
| dbus_oe | output | 1 | Data drive enable |

## Verification
The call sequence is run for a single request, for two simultaneous requests, and for a request that arrives in the middle of a sequence. These cases separate the correct priority choice and the freezing of the level at the first acknowledge from a design that re-evaluates priority on every pulse. Both vector spacings are exercised, together with a base and level whose sum wraps past 0xFF. This exposes a wrong shift amount or a carry that leaks into the high byte. A request raised before setup is complete shows that the request line is gated and that the capture is not lost. The request line is checked between pulses and after each sequence, which shows that only the serviced pending bit is cleared.

// File: rtl/callseq_pkg.sv
package callseq_pkg;
    localparam int unsigned NUM_LVL  = 8;
    localparam int unsigned LVL_W    = $clog2(NUM_LVL);
    localparam int unsigned BYTE_W   = 8;
    localparam logic [7:0]  CALL_OP  = 8'hCD;

    typedef enum logic [1:0] {
        STEP_OPC  = 2'd0,
        STEP_HIGH = 2'd1,
        STEP_LOW  = 2'd2
    } ack_step_e;

    typedef struct packed {
        logic [BYTE_W-1:0] word_lo;
        logic [BYTE_W-1:0] word_hi;
        logic              got_lo;
        logic              got_hi;
    } setup_t;

    typedef struct packed {
        ack_step_e         step;
        logic              busy;
        logic [LVL_W-1:0]  level;
        logic              inta_q;
    } seq_t;
endpackage

// File: rtl/csq_setup_regs.sv
module csq_setup_regs
    import callseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] word_lo,
    output logic [BYTE_W-1:0] word_hi,
    output logic              ready
);
    setup_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_sel) begin
                cfg_d.word_hi = wr_data;
                cfg_d.got_hi  = 1'b1;
            end else begin
                cfg_d.word_lo = wr_data;
                cfg_d.got_lo  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign word_lo = cfg_q.word_lo;
    assign word_hi = cfg_q.word_hi;
    assign ready   = cfg_q.got_lo & cfg_q.got_hi;
endmodule

// File: rtl/csq_pending.sv
module csq_pending
    import callseq_pkg::*;
#(
    parameter int unsigned N = NUM_LVL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_d, req_q;
    logic [N-1:0] pend_d, pend_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            req_d[g]  = req_in[g];
            pend_d[g] = (pend_q[g] & ~clr[g]) | (req_in[g] & ~req_q[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/csq_prio_pick.sv
module csq_prio_pick
    import callseq_pkg::*;
#(
    parameter int unsigned N = NUM_LVL,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] pend,
    output logic [W-1:0] win,
    output logic         any
);
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) win = W'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/csq_ack_seq.sv
module csq_ack_seq
    import callseq_pkg::*;
#(
    parameter int unsigned N = NUM_LVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inta_n,
    input  logic              ready,
    input  logic              any,
    input  logic [LVL_W-1:0]  win,
    input  logic [BYTE_W-1:0] word_lo,
    input  logic [BYTE_W-1:0] word_hi,
    output logic [N-1:0]      clr,
    output logic              intr,
    output logic [BYTE_W-1:0] dbus,
    output logic              dbus_en,
    output logic              busy,
    output logic [1:0]        step
);
    seq_t st_d, st_q;
    logic fall, rise;
    logic [BYTE_W-1:0] base, offs, lo_byte;

    always_comb begin
        fall = ~inta_n &  st_q.inta_q;
        rise =  inta_n & ~st_q.inta_q;
        st_d = st_q;
        st_d.inta_q = inta_n;
        clr = '0;
        if (fall && !st_q.busy && st_q.step == STEP_OPC && ready) begin
            st_d.busy  = 1'b1;
            st_d.level = win;
        end
        if (rise && st_q.busy) begin
            unique case (st_q.step)
                STEP_OPC:  st_d.step = STEP_HIGH;
                STEP_HIGH: st_d.step = STEP_LOW;
                default: begin
                    st_d.step = STEP_OPC;
                    st_d.busy = 1'b0;
                    clr[st_q.level] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.inta_q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        base = {word_lo[7:5], 5'b00000};
        if (word_lo[2]) offs = BYTE_W'({st_q.level, 2'b00});
        else            offs = BYTE_W'({st_q.level, 3'b000});
        lo_byte = base + offs;
        dbus_en = ~inta_n & ready & (st_q.busy | (st_q.step == STEP_OPC));
        dbus = '0;
        if (dbus_en) begin
            unique case (st_q.step)
                STEP_OPC:  dbus = CALL_OP;
                STEP_HIGH: dbus = word_hi;
                default:   dbus = lo_byte;
            endcase
        end
        intr = ready & any & ~st_q.busy & inta_n;
    end

    assign busy = st_q.busy;
    assign step = st_q.step;
endmodule

// File: rtl/callseq_irq_ctrl.sv
module callseq_irq_ctrl
    import callseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] irq_in,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       inta_n,
    output logic       intr_o,
    output logic [7:0] dbus_o,
    output logic       dbus_oe
);
    logic [BYTE_W-1:0]  word_lo, word_hi;
    logic               cfg_ready;
    logic [NUM_LVL-1:0] pend, clr;
    logic [LVL_W-1:0]   win;
    logic               any;
    logic               seq_busy;
    logic [1:0]         seq_step;

    csq_setup_regs u_setup (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
        .wr_data(cfg_wdata), .word_lo(word_lo), .word_hi(word_hi),
        .ready(cfg_ready)
    );

    csq_pending #(.N(NUM_LVL)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_in(irq_in), .clr(clr), .pend(pend)
    );

    csq_prio_pick #(.N(NUM_LVL)) u_pick (
        .pend(pend), .win(win), .any(any)
    );

    csq_ack_seq #(.N(NUM_LVL)) u_seq (
        .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .ready(cfg_ready),
        .any(any), .win(win), .word_lo(word_lo), .word_hi(word_hi),
        .clr(clr), .intr(intr_o), .dbus(dbus_o), .dbus_en(dbus_oe),
        .busy(seq_busy), .step(seq_step)
    );
endmodule

// File: rtl/csq_checker.sv
module csq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       inta_n,
    input logic       intr_o,
    input logic [7:0] dbus_o,
    input logic       dbus_oe,
    input logic       ready,
    input logic       busy,
    input logic [1:0] step
);
    assert_gate_until_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !intr_o);

    assert_drive_only_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> !inta_n);

    assert_first_byte_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_oe && step == 2'd0) |-> dbus_o == 8'hCD);

    assert_request_withdrawn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !intr_o);

    assert_return_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 2'd2 && busy && inta_n && !$past(inta_n)) |=> (step == 2'd0 && !busy));
endmodule

bind callseq_irq_ctrl csq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .intr_o(intr_o),
    .dbus_o(dbus_o), .dbus_oe(dbus_oe), .ready(cfg_ready),
    .busy(seq_busy), .step(seq_step)
);

// File: tb/sim_callseq_irq_ctrl.sv
module sim_callseq_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       inta_n = 1'b1;
    logic       intr_o;
    logic [7:0] dbus_o;
    logic       dbus_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] hi_word;

    always #5 clk = ~clk;

    callseq_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .inta_n(inta_n),
        .intr_o(intr_o), .dbus_o(dbus_o), .dbus_oe(dbus_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare every driven acknowledge byte with the scoreboard
    initial begin
        forever begin
            @(negedge inta_n);
            #2;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected ack", dbus_o, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dbus_oe === 1'b1 && dbus_o === e, t, {dbus_oe, dbus_o}, {1'b1, e});
            end
        end
    end

    task automatic write_cfg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_irq(input int lvl);
        @(negedge clk);
        irq_in[lvl] = 1'b1;
        @(negedge clk);
        irq_in[lvl] = 1'b0;
    endtask

    task automatic one_ack(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        inta_n = 1'b0;
        @(negedge clk);
        inta_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    // full call sequence; the first two gaps must keep the request low (R8)
    task automatic call_seq(input logic [7:0] lo);
        one_ack(8'hCD, "R4 opcode");
        check(intr_o === 1'b0 && dbus_oe === 1'b0, "R8 gap1", {intr_o, dbus_oe}, 0);
        one_ack(hi_word, "R5 high byte");
        check(intr_o === 1'b0, "R8 gap2", intr_o, 0);
        one_ack(lo, "R6 low byte");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        hi_word = 8'h12;
        repeat (3) @(negedge clk);
        check(intr_o === 1'b0 && dbus_oe === 1'b0, "R10 reset outputs", {intr_o, dbus_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: request captured before setup is held but not signalled
        pulse_irq(3);
        #1;
        check(intr_o === 1'b0, "R1 no setup", intr_o, 0);
        write_cfg(1'b0, 8'hA4);      // base A0, spacing 4
        #1;
        check(intr_o === 1'b0, "R1 only word one", intr_o, 0);
        write_cfg(1'b1, hi_word);
        #1;
        check(intr_o === 1'b1, "R1 R2 raised after setup", intr_o, 1);

        call_seq(8'hAC);             // level 3: A0 + 12
        check(intr_o === 1'b0, "R9 nothing left", intr_o, 0);

        // R2 edge capture of a fresh request
        pulse_irq(4);
        #1;
        check(intr_o === 1'b1, "R2 edge sets request", intr_o, 1);
        call_seq(8'hB0);

        // R3 simultaneous requests on levels 5 and 2
        @(negedge clk);
        irq_in[5] = 1'b1; irq_in[2] = 1'b1;
        @(negedge clk);
        irq_in = '0;
        #1;
        check(intr_o === 1'b1, "R2 both pending", intr_o, 1);
        call_seq(8'hA8);             // level 2 wins
        check(intr_o === 1'b1, "R9 level 5 still pending", intr_o, 1);
        call_seq(8'hB4);             // level 5
        check(intr_o === 1'b0, "R9 all cleared", intr_o, 0);

        // R7 freeze: level 1 arrives after first acknowledge of level 6
        pulse_irq(6);
        one_ack(8'hCD, "R4 opcode");
        pulse_irq(1);
        #1;
        check(intr_o === 1'b0, "R8 new request mid sequence", intr_o, 0);
        one_ack(hi_word, "R5 high byte");
        one_ack(8'hB8, "R7 frozen level 6");
        check(intr_o === 1'b1, "R9 level 1 pending after", intr_o, 1);
        call_seq(8'hA4);

        // R6 spacing 8 and wrap
        write_cfg(1'b0, 8'h40);
        hi_word = 8'h9E;
        write_cfg(1'b1, hi_word);
        pulse_irq(7);
        call_seq(8'h78);             // 40 + 56
        write_cfg(1'b0, 8'hE0);
        pulse_irq(7);
        call_seq(8'h18);             // E0 + 38 wraps
        @(negedge clk);
        check(dbus_oe === 1'b0 && exp_q.size() == 0, "R4 idle no drive", dbus_oe, 0);

        // R10 reset mid sequence returns to idle
        pulse_irq(0);
        one_ack(8'hCD, "R4 opcode");
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(intr_o === 1'b0 && dbus_oe === 1'b0, "R10 reset mid sequence", {intr_o, dbus_oe}, 0);
        rst_n = 1'b1;
        pulse_irq(0);
        #1;
        check(intr_o === 1'b0, "R10 R1 setup cleared by reset", intr_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule